// File: doc/BRIEF.md
# Network Ejection to AXI4 Write Bridge

This block sits on one receive port of an on-chip network and turns every flit that the port ejects into a single-beat AXI4 write toward an attached slave. The network offers at most one flit per cycle. Each flit carries a tail mark, a destination identifier, a virtual-channel number and a payload as wide as the AXI data bus. Each virtual channel owns a one-entry holding register. Every cycle the bridge returns a per-channel vector of not-full flags, so the network places a flit only where space exists. This is level-based "peek" flow control, not credit counting.

A small state machine takes the lowest-numbered occupied channel. It presents the address and data beats together, waits for the write response and only then frees the channel. The bridge also outputs its own receive-port number as a constant, so clients can form response addresses. It issues writes only. A sticky error flag records traffic that this single-beat bridge cannot honour.

Top module: `noc_eject_axi_wr`

## Requirements
- R1: After reset every not-full flag is 1, `m_awvalid_o`, `m_wvalid_o`, `m_bready_o` and `err_o` are 0.
- R2: `port_id_o` always equals the PORT_ID parameter.
- R3: A flit offered with `flit_valid_i` high on channel v is stored at the next clock edge, `vc_not_full_o[v]` reads 0 from that edge on, and one write carrying the flit payload on `m_wdata_o` follows.
- R4: The address beat has `m_awaddr_o` equal to ADDR_BASE with its low DST_W bits replaced by the flit destination, `m_awlen_o` = 0, `m_awsize_o` = log2(DATA_W/8) and `m_awburst_o` = 2'b01 (incrementing).
- R5: The data beat has `m_wstrb_o` all ones and `m_wlast_o` = 1.
- R6: Address and data valids rise together; each stays high with stable contents until its own ready is seen, and the two handshakes may complete in different cycles.
- R7: When several channels hold flits while the bridge is idle, the lowest-numbered channel is written first.
- R8: `m_bready_o` is raised only after both the address and data handshakes have completed; the channel is freed by the response handshake and its not-full flag reads 1 on the cycle after it.
- R9: A valid flit offered to a channel whose flag is 0 sets `err_o` and leaves the stored flit unchanged.
- R10: A valid flit with the tail mark at 0 sets `err_o`; it is still written as one beat.
- R11: A write response with `m_bresp_i` other than 2'b00 sets `err_o`.
- R12: Once set, `err_o` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flit_valid_i | input | 1 | Ejected flit present this cycle |
| flit_tail_i | input | 1 | Tail mark of the flit |
| flit_dst_i | input | DST_W | Destination identifier of the flit |
| flit_vc_i | input | VC_W | Virtual channel of the flit |
| flit_data_i | input | DATA_W | Flit payload |
| vc_not_full_o | output | NUM_VC | Per-channel space available flags |
| port_id_o | output | DST_W | Constant receive-port identifier |
| m_awvalid_o | output | 1 | Write address valid |
| m_awready_i | input | 1 | Write address ready |
| m_awaddr_o | output | ADDR_W | Write address |
| m_awlen_o | output | 8 | Burst length minus one (always 0) |
| m_awsize_o | output | 3 | Beat size code |
| m_awburst_o | output | 2 | Burst type |
| m_wvalid_o | output | 1 | Write data valid |
| m_wready_i | input | 1 | Write data ready |
| m_wdata_o | output | DATA_W | Write data |
| m_wstrb_o | output | DATA_W/8 | Byte strobes |
| m_wlast_o | output | 1 | Last beat mark |
| m_bvalid_i | input | 1 | Write response valid |
| m_bready_o | output | 1 | Write response ready |
| m_bresp_i | input | 2 | Write response code |
| err_o | output | 1 | Sticky protocol error flag |

## Verification
The bench builds the bridge with four virtual channels, a 32-bit data bus, a 3-bit destination field, PORT_ID 5 and a base address whose low three bits are cleared. Four channels let one flit stay in flight on the top channel while two lower ones fill. This makes the drain order visible at the ports, which a two-channel build cannot show, because the freed channel is always the one that just finished. The 32-bit bus gives a non-trivial size code, and the cleared base bits show the destination merged into the address.

// File: rtl/nab_pkg.sv
package nab_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_RESP = 2'd2
  } wr_state_e;

  localparam logic [1:0] BURST_INCR = 2'b01;
  localparam logic [1:0] RESP_OKAY  = 2'b00;

  // beat size code for a bus of the given byte count
  function automatic logic [2:0] size_code(input int unsigned nbytes);
    logic [2:0] code;
    code = 3'd0;
    for (int k = 0; k < 8; k++) begin
      if ((32'd1 << k) == nbytes) code = 3'(k);
    end
    return code;
  endfunction

endpackage

// File: rtl/nab_vc_slot.sv
module nab_vc_slot #(
  parameter int DATA_W = 64,
  parameter int DST_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [DST_W-1:0]  dst_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              release_i,
  output logic              occupied_o,
  output logic [DST_W-1:0]  dst_o,
  output logic [DATA_W-1:0] data_o,
  output logic              overflow_o
);

  logic              occ_q;
  logic [DST_W-1:0]  dst_q;
  logic [DATA_W-1:0] data_q;
  logic              accept;

  assign accept     = push_i && !occ_q;
  assign overflow_o = push_i && occ_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ_q  <= 1'b0;
      dst_q  <= '0;
      data_q <= '0;
    end else begin
      if (release_i) occ_q <= 1'b0;
      if (accept) begin
        occ_q  <= 1'b1;
        dst_q  <= dst_i;
        data_q <= data_i;
      end
    end
  end

  assign occupied_o = occ_q;
  assign dst_o      = dst_q;
  assign data_o     = data_q;

  // R9
  keep_on_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow_o && !release_i) |=> (occ_q && $stable(data_q) && $stable(dst_q)));

endmodule

// File: rtl/nab_pick.sv
module nab_pick #(
  parameter int N     = 2,
  parameter int IDX_W = 1
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |req_i;

endmodule

// File: rtl/nab_wr_fsm.sv
module nab_wr_fsm
  import nab_pkg::*;
#(
  parameter int IDX_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any_i,
  input  logic [IDX_W-1:0] pick_i,
  input  logic             awready_i,
  input  logic             wready_i,
  input  logic             bvalid_i,
  output logic             awvalid_o,
  output logic             wvalid_o,
  output logic             bready_o,
  output logic [IDX_W-1:0] sel_o,
  output logic             done_o
);

  wr_state_e        state_q;
  logic [IDX_W-1:0] sel_q;
  logic             aw_done_q, w_done_q;
  logic             aw_fire, w_fire, aw_ok, w_ok;

  assign awvalid_o = (state_q == ST_SEND) && !aw_done_q;
  assign wvalid_o  = (state_q == ST_SEND) && !w_done_q;
  assign bready_o  = (state_q == ST_RESP);
  assign aw_fire   = awvalid_o && awready_i;
  assign w_fire    = wvalid_o && wready_i;
  assign aw_ok     = aw_fire || aw_done_q;
  assign w_ok      = w_fire || w_done_q;
  assign done_o    = bready_o && bvalid_i;
  assign sel_o     = sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      sel_q     <= '0;
      aw_done_q <= 1'b0;
      w_done_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (any_i) begin
          sel_q   <= pick_i;
          state_q <= ST_SEND;
        end
        ST_SEND: begin
          if (aw_ok && w_ok) begin
            state_q   <= ST_RESP;
            aw_done_q <= 1'b0;
            w_done_q  <= 1'b0;
          end else begin
            aw_done_q <= aw_ok;
            w_done_q  <= w_ok;
          end
        end
        ST_RESP: if (bvalid_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R6
  aw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (awvalid_o && !awready_i) |=> (awvalid_o && $stable(sel_q)));
  // R6
  w_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wvalid_o && !wready_i) |=> (wvalid_o && $stable(sel_q)));
  // R8
  resp_after_beats_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bready_o) |-> !awvalid_o && !wvalid_o && ($past(aw_fire) || $past(w_fire)));

endmodule

// File: rtl/noc_eject_axi_wr.sv
module noc_eject_axi_wr
  import nab_pkg::*;
#(
  parameter int              NUM_VC    = 2,
  parameter int              DATA_W    = 64,
  parameter int              DST_W     = 2,
  parameter int              ADDR_W    = 32,
  parameter int              PORT_ID   = 1,
  parameter logic [ADDR_W-1:0] ADDR_BASE = '0,
  localparam int             VC_W      = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  localparam int             STRB_W    = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flit_valid_i,
  input  logic              flit_tail_i,
  input  logic [DST_W-1:0]  flit_dst_i,
  input  logic [VC_W-1:0]   flit_vc_i,
  input  logic [DATA_W-1:0] flit_data_i,
  output logic [NUM_VC-1:0] vc_not_full_o,
  output logic [DST_W-1:0]  port_id_o,
  output logic              m_awvalid_o,
  input  logic              m_awready_i,
  output logic [ADDR_W-1:0] m_awaddr_o,
  output logic [7:0]        m_awlen_o,
  output logic [2:0]        m_awsize_o,
  output logic [1:0]        m_awburst_o,
  output logic              m_wvalid_o,
  input  logic              m_wready_i,
  output logic [DATA_W-1:0] m_wdata_o,
  output logic [STRB_W-1:0] m_wstrb_o,
  output logic              m_wlast_o,
  input  logic              m_bvalid_i,
  output logic              m_bready_o,
  input  logic [1:0]        m_bresp_i,
  output logic              err_o
);

  localparam logic [ADDR_W-1:0] ID_MASK = {{(ADDR_W-DST_W){1'b0}}, {DST_W{1'b1}}};

  logic [NUM_VC-1:0] push_vec, rel_vec, occ_vec, ovf_vec;
  logic [DST_W-1:0]  slot_dst  [NUM_VC];
  logic [DATA_W-1:0] slot_data [NUM_VC];
  logic              any_occ, b_fire, err_q;
  logic [VC_W-1:0]   pick_idx, sel_idx;
  logic              nontail_evt, ovf_evt, bad_resp_evt;

  for (genvar g = 0; g < NUM_VC; g++) begin : g_slot
    assign push_vec[g] = flit_valid_i && (flit_vc_i == VC_W'(g));
    assign rel_vec[g]  = b_fire && (sel_idx == VC_W'(g));
    nab_vc_slot #(.DATA_W(DATA_W), .DST_W(DST_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_i    (push_vec[g]),
      .dst_i     (flit_dst_i),
      .data_i    (flit_data_i),
      .release_i (rel_vec[g]),
      .occupied_o(occ_vec[g]),
      .dst_o     (slot_dst[g]),
      .data_o    (slot_data[g]),
      .overflow_o(ovf_vec[g])
    );
  end

  nab_pick #(.N(NUM_VC), .IDX_W(VC_W)) u_pick (
    .req_i(occ_vec),
    .any_o(any_occ),
    .idx_o(pick_idx)
  );

  nab_wr_fsm #(.IDX_W(VC_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .any_i    (any_occ),
    .pick_i   (pick_idx),
    .awready_i(m_awready_i),
    .wready_i (m_wready_i),
    .bvalid_i (m_bvalid_i),
    .awvalid_o(m_awvalid_o),
    .wvalid_o (m_wvalid_o),
    .bready_o (m_bready_o),
    .sel_o    (sel_idx),
    .done_o   (b_fire)
  );

  assign m_awaddr_o  = (ADDR_BASE & ~ID_MASK) | {{(ADDR_W-DST_W){1'b0}}, slot_dst[sel_idx]};
  assign m_awlen_o   = 8'd0;
  assign m_awsize_o  = size_code(STRB_W);
  assign m_awburst_o = BURST_INCR;
  assign m_wdata_o   = slot_data[sel_idx];
  assign m_wstrb_o   = '1;
  assign m_wlast_o   = 1'b1;

  assign vc_not_full_o = ~occ_vec;
  assign port_id_o     = DST_W'(PORT_ID);

  assign ovf_evt      = |ovf_vec;
  assign nontail_evt  = flit_valid_i && !flit_tail_i;
  assign bad_resp_evt = b_fire && (m_bresp_i != RESP_OKAY);

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else if (ovf_evt || nontail_evt || bad_resp_evt) err_q <= 1'b1;
  end
  assign err_o = err_q;

  // R12
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);
  // R8
  free_after_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b_fire |=> (vc_not_full_o != $past(vc_not_full_o)));
  // R7
  one_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_awvalid_o) |-> $countones(occ_vec & ((NUM_VC)'(1) << sel_idx)) == 1);
  // R2
  port_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(port_id_o));

endmodule

// File: tb/noc_eject_axi_wr_tb.sv
module noc_eject_axi_wr_tb;
  localparam int CLK_P  = 10;
  localparam int NVC    = 4;
  localparam int DW     = 32;
  localparam int DSTW   = 3;
  localparam int AW     = 32;
  localparam int PID    = 5;
  localparam logic [31:0] BASE = 32'h8000_1230;
  localparam int NVEC   = 6;
  // {mode[3:0], vc[3:0], dst[7:0], data[31:0]}
  localparam logic [47:0] VEC [NVEC] = '{
    {4'd0, 4'd0, 8'd5, 32'h1234_5678},
    {4'd1, 4'd1, 8'd2, 32'hDEAD_BEEF},
    {4'd2, 4'd3, 8'd7, 32'h0000_0001},
    {4'd0, 4'd2, 8'd0, 32'hFFFF_FFFF},
    {4'd1, 4'd0, 8'd1, 32'hA5A5_5A5A},
    {4'd2, 4'd2, 8'd6, 32'h0F0F_F0F0}
  };

  logic clk = 0, rst_n = 0;
  logic flit_valid = 0, flit_tail = 1;
  logic [DSTW-1:0] flit_dst = 0;
  logic [1:0] flit_vc = 0;
  logic [DW-1:0] flit_data = 0;
  logic [NVC-1:0] not_full;
  logic [DSTW-1:0] port_id;
  logic awvalid, awready = 0, wvalid, wready = 0, wlast, bvalid = 0, bready, err;
  logic [AW-1:0] awaddr;
  logic [7:0] awlen;
  logic [2:0] awsize;
  logic [1:0] awburst, bresp = 0;
  logic [DW-1:0] wdata;
  logic [DW/8-1:0] wstrb;
  int total = 0, bad = 0;
  bit ended = 0;

  always #(CLK_P/2) clk = ~clk;

  noc_eject_axi_wr #(.NUM_VC(NVC), .DATA_W(DW), .DST_W(DSTW), .ADDR_W(AW),
                     .PORT_ID(PID), .ADDR_BASE(BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .flit_valid_i(flit_valid), .flit_tail_i(flit_tail),
    .flit_dst_i(flit_dst), .flit_vc_i(flit_vc), .flit_data_i(flit_data),
    .vc_not_full_o(not_full), .port_id_o(port_id),
    .m_awvalid_o(awvalid), .m_awready_i(awready), .m_awaddr_o(awaddr),
    .m_awlen_o(awlen), .m_awsize_o(awsize), .m_awburst_o(awburst),
    .m_wvalid_o(wvalid), .m_wready_i(wready), .m_wdata_o(wdata),
    .m_wstrb_o(wstrb), .m_wlast_o(wlast), .m_bvalid_i(bvalid),
    .m_bready_o(bready), .m_bresp_i(bresp), .err_o(err));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; flit_valid = 0; awready = 0; wready = 0; bvalid = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic send(input int vc, input int dst, input logic [DW-1:0] d, input bit tail);
    @(negedge clk);
    flit_valid = 1; flit_vc = 2'(vc); flit_dst = DSTW'(dst); flit_data = d; flit_tail = tail;
    @(negedge clk);
    flit_valid = 0; flit_tail = 1;
    chk(not_full[vc] == 1'b0, "R3 flag low after store", 64'(not_full[vc]), 0);
  endtask

  task automatic wait_req();
    for (int i = 0; i < 50; i++) begin
      if (awvalid && wvalid) return;
      @(negedge clk);
    end
    chk(0, "R3 write not issued", 0, 1);
  endtask

  task automatic serve(input int mode, input int vc, input int dst, input logic [DW-1:0] d,
                       input logic [1:0] rsp);
    logic [AW-1:0] ea;
    ea = (BASE & ~32'h7) | AW'(dst);
    wait_req();
    chk(awaddr == ea, "R4 awaddr", 64'(awaddr), 64'(ea));
    chk(awlen == 0 && awsize == 3'd2 && awburst == 2'b01, "R4 len/size/burst",
        {awlen, 3'b0, awsize, 2'b0, awburst}, {8'd0, 3'b0, 3'd2, 2'b0, 2'b01});
    chk(wdata == d, "R3 wdata", 64'(wdata), 64'(d));
    chk(wstrb == 4'hF && wlast, "R5 strb/last", {wstrb, 3'b0, wlast}, {4'hF, 4'h1});
    if (mode == 0) begin
      awready = 1; wready = 1; @(negedge clk); awready = 0; wready = 0;
    end else if (mode == 1) begin
      awready = 1; @(negedge clk); awready = 0;
      chk(!awvalid && wvalid && wdata == d, "R6 w held after aw", {awvalid, wvalid}, 2'b01);
      chk(!bready, "R8 no bready before w", 64'(bready), 0);
      wready = 1; @(negedge clk); wready = 0;
    end else begin
      wready = 1; @(negedge clk); wready = 0;
      chk(awvalid && !wvalid && awaddr == ea, "R6 aw held after w", {awvalid, wvalid}, 2'b10);
      chk(!bready, "R8 no bready before aw", 64'(bready), 0);
      awready = 1; @(negedge clk); awready = 0;
    end
    chk(bready && !awvalid && !wvalid, "R8 bready after beats", {bready, awvalid, wvalid}, 3'b100);
    chk(not_full[vc] == 0, "R8 held until resp", 64'(not_full[vc]), 0);
    bvalid = 1; bresp = rsp; @(negedge clk); bvalid = 0; bresp = 0;
    chk(not_full[vc] == 1, "R8 freed after resp", 64'(not_full[vc]), 1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1; total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk(not_full == 4'hF && !awvalid && !wvalid && !bready && !err, "R1 reset state",
        {not_full, awvalid, wvalid, bready, err}, {4'hF, 4'h0});
    chk(port_id == 3'(PID), "R2 port id", 64'(port_id), PID);

    for (int i = 0; i < NVEC; i++) begin
      send(int'(VEC[i][43:40]), int'(VEC[i][39:32]), VEC[i][31:0], 1);
      serve(int'(VEC[i][47:44]), int'(VEC[i][43:40]), int'(VEC[i][39:32]), VEC[i][31:0], 2'b00);
    end
    chk(!err, "R12 no error on clean traffic", 64'(err), 0);

    // R7: vc3 in flight, then vc2 and vc1 fill; vc1 must go first
    send(3, 1, 32'hAAAA_0003, 1);
    wait_req();
    send(2, 2, 32'hAAAA_0002, 1);
    send(1, 3, 32'hAAAA_0001, 1);
    serve(0, 3, 1, 32'hAAAA_0003, 2'b00);
    serve(0, 1, 3, 32'hAAAA_0001, 2'b00);   // R7 lower channel first
    serve(0, 2, 2, 32'hAAAA_0002, 2'b00);

    // R9 overflow
    do_reset();
    send(0, 4, 32'h0000_00D0, 1);
    chk(!err, "R9 no error before overflow", 64'(err), 0);
    send(0, 6, 32'h0000_00E0, 1);
    chk(err, "R9 overflow sets err", 64'(err), 1);
    serve(0, 0, 4, 32'h0000_00D0, 2'b00);
    chk(err, "R12 err stays set", 64'(err), 1);
    do_reset();
    @(negedge clk);
    chk(!err, "R1 reset clears err", 64'(err), 0);

    // R10 non-tail flit
    send(1, 2, 32'h0000_7A11, 0);
    chk(err, "R10 non-tail sets err", 64'(err), 1);
    serve(0, 1, 2, 32'h0000_7A11, 2'b00);

    // R11 error response
    do_reset();
    send(2, 3, 32'h0000_BAD0, 1);
    serve(1, 2, 3, 32'h0000_BAD0, 2'b10);
    chk(err, "R11 slverr sets err", 64'(err), 1);

    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule